// File: doc/BRIEF.md
# Multi-channel FIFO read port

This block holds several independent first-in first-out channels in one shared storage array. Every channel keeps its own read pointer, write pointer and fill count. Each stored word carries a small tag next to its data, and the tag is one eighth of the data width. A simple write port fills any channel chosen by number.

A single consumer reads from the channels. It drives a channel number to pick the active channel. After any change of that number, the channel-valid output stays low for one cycle while the block loads the new channel's status, and then it rises. While channel-valid is high, the consumer can raise a read request. One cycle later the block answers with exactly one of two signals:
- a data acknowledge, which comes with the oldest word and its tag;
- an error acknowledge, when the channel was empty.

A request flagged as a burst makes the block deliver a fixed number of words on back-to-back cycles with no further requests. If the channel runs dry partway through, the burst ends early with an error acknowledge. Two occupancy flags describe the active channel only: almost-empty and half-empty.

Top module: `mchan_fifo_rd`

## Requirements
- R1: While reset is held and on the first cycle after it, acknowledge and error acknowledge are low, channel-valid is low, every channel is empty, half-empty is high and almost-empty is low. One cycle after reset is released, channel-valid goes high when the channel number is unchanged.
- R2: When the channel-number input differs from the active channel at a clock edge, that channel becomes active and channel-valid is low for the following cycle. If the number then holds steady, channel-valid is high from the next cycle on. Read requests seen at either of those two edges are ignored: they produce no acknowledge, no error acknowledge and no change in any count.
- R3: A read request sampled while channel-valid is high on a non-empty active channel raises acknowledge for the next cycle. During that cycle the data output carries the oldest word of that channel, and the channel count drops by one.
- R4: A read request to an empty active channel raises error acknowledge for the next cycle instead of acknowledge, and it changes no count.
- R5: The tag output has DATA_W/8 bits and shows, during acknowledge, the tag that was written with the same word.
- R6: Almost-empty is high exactly when the active channel holds one word.
- R7: Half-empty is high exactly when the active channel holds DEPTH/2 words or fewer.
- R8: Channels are independent. Writes to one channel do not change another channel's contents, order or flags, and each channel returns its words in the order they were written.
- R9: A write to a channel that already holds DEPTH words is discarded, and the channel count never exceeds DEPTH.
- R10: A read and a write to the same channel in the same cycle leave that channel's count unchanged. The written word joins the tail of the channel.
- R11: A request accepted with the burst input high delivers BURST_LEN acknowledges on consecutive cycles without further requests. The first of these is the normal one-cycle-later acknowledge.
- R12: If the channel becomes empty during a burst, the next beat gives error acknowledge and the burst stops. No further acknowledge follows unless there is a new request.
- R13: Acknowledge and error acknowledge are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_ch | input | CH_W | Channel to write |
| wr_data | input | DATA_W | Data word to write |
| wr_tag | input | DATA_W/8 | Tag stored with the word |
| ch_sel | input | CH_W | Channel number for reads |
| rd_req | input | 1 | Read request, active high |
| rd_burst | input | 1 | Marks the request as a fixed-length burst |
| ch_valid | output | 1 | Status of the active channel is valid; reads accepted |
| rd_ack | output | 1 | Data acknowledge; data and tag are valid |
| rd_err_ack | output | 1 | Error acknowledge for a read of an empty channel |
| rd_data | output | DATA_W | Read data |
| rd_tag | output | DATA_W/8 | Tag of the read word |
| half_empty | output | 1 | Active channel holds at most half its depth |
| almost_empty | output | 1 | Active channel holds exactly one word |

## Verification
The bench builds the block with four channels of depth four, a 16-bit data word with a 2-bit tag, and a burst length of three. With a depth of four, every fill level from empty to full and one write past full can be swept on every channel. That sweep reaches both flag thresholds and the discarded write. A three-beat burst on a channel holding two words reaches the early error ending within a few cycles. With four channels, interleaved writes can show that order and flags stay separate per channel.

// File: rtl/mcf_pkg.sv
`timescale 1ns/1ps
package mcf_pkg;

    // Outcome of a read decision in one cycle.
    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_DATA = 2'd1,
        RD_ERR  = 2'd2
    } rd_kind_e;

    // Bits needed to index n items, never less than one.
    function automatic int width_for(int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/mcf_store.sv
`timescale 1ns/1ps
// Shared word storage, partitioned by channel: address = {channel, pointer}.
module mcf_store #(
    parameter int NUM_CH = 4,
    parameter int DEPTH  = 8,
    parameter int WORD_W = 36,
    localparam int CH_W  = mcf_pkg::width_for(NUM_CH),
    localparam int PTR_W = mcf_pkg::width_for(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [CH_W-1:0]   wch,
    input  logic [PTR_W-1:0]  wptr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [CH_W-1:0]   rch,
    input  logic [PTR_W-1:0]  rptr,
    output logic [WORD_W-1:0] rdata
);
    localparam int ADDR_W  = CH_W + PTR_W;
    localparam int ENTRIES = 1 << ADDR_W;

    logic [WORD_W-1:0] mem_q [ENTRIES];
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;

    assign waddr = {wch, wptr};
    assign raddr = {rch, rptr};

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/mcf_chan_ptrs.sv
`timescale 1ns/1ps
// Per-channel read pointer, write pointer and fill count.
module mcf_chan_ptrs #(
    parameter int NUM_CH = 4,
    parameter int DEPTH  = 8,
    localparam int CH_W  = mcf_pkg::width_for(NUM_CH),
    localparam int PTR_W = mcf_pkg::width_for(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [CH_W-1:0]              wr_ch,
    input  logic                         rd_pop,
    input  logic [CH_W-1:0]              rd_ch,
    output logic                         wr_accept,
    output logic [PTR_W-1:0]             wr_ptr,
    output logic [PTR_W-1:0]             rd_ptr,
    output logic [NUM_CH-1:0][CNT_W-1:0] cnt_all
);
    localparam bit CH_POW2 = (NUM_CH == (1 << CH_W));

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
    } chan_t;

    logic [NUM_CH-1:0][PTR_W-1:0] wptr_all;
    logic [NUM_CH-1:0][PTR_W-1:0] rptr_all;
    logic                         wr_in_range;

    assign wr_in_range = CH_POW2 || ({1'b0, wr_ch} < (CH_W+1)'(NUM_CH));
    assign wr_accept   = wr_en && wr_in_range && (cnt_all[wr_ch] != CNT_W'(DEPTH));
    assign wr_ptr      = wptr_all[wr_ch];
    assign rd_ptr      = rptr_all[rd_ch];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        chan_t ch_d, ch_q;
        logic  push, pop;

        assign push = wr_accept && (wr_ch == CH_W'(g));
        assign pop  = rd_pop && (rd_ch == CH_W'(g));

        always_comb begin
            ch_d = ch_q;
            if (push) ch_d.wptr = ch_q.wptr + 1'b1;
            if (pop)  ch_d.rptr = ch_q.rptr + 1'b1;
            case ({push, pop})
                2'b10:   ch_d.cnt = ch_q.cnt + 1'b1;
                2'b01:   ch_d.cnt = ch_q.cnt - 1'b1;
                default: ch_d.cnt = ch_q.cnt;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ch_q <= '0;
            else        ch_q <= ch_d;
        end

        assign wptr_all[g] = ch_q.wptr;
        assign rptr_all[g] = ch_q.rptr;
        assign cnt_all[g]  = ch_q.cnt;

        assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ch_q.cnt <= CNT_W'(DEPTH));
        assert_rw_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (push && pop) |=> $stable(ch_q.cnt));
        assert_no_pop_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
            pop |-> (ch_q.cnt != '0));
    end

endmodule

// File: rtl/mcf_rd_ctrl.sv
`timescale 1ns/1ps
// Channel selection, read handshake, burst sequencing and occupancy flags.
module mcf_rd_ctrl
    import mcf_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int DEPTH     = 8,
    parameter int DATA_W    = 32,
    parameter int BURST_LEN = 4,
    localparam int TAG_W    = DATA_W / 8,
    localparam int CH_W     = width_for(NUM_CH),
    localparam int PTR_W    = width_for(DEPTH),
    localparam int CNT_W    = PTR_W + 1,
    localparam int BL_W     = width_for(BURST_LEN + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [CH_W-1:0]              ch_sel,
    input  logic                         rd_req,
    input  logic                         rd_burst,
    input  logic [NUM_CH-1:0][CNT_W-1:0] cnt_all,
    input  logic [DATA_W+TAG_W-1:0]      mem_word,
    output logic                         rd_pop,
    output logic [CH_W-1:0]              active_ch,
    output logic                         ch_valid,
    output logic                         rd_ack,
    output logic                         rd_err_ack,
    output logic [DATA_W-1:0]            rd_data,
    output logic [TAG_W-1:0]             rd_tag,
    output logic                         half_empty,
    output logic                         almost_empty
);
    localparam bit CH_POW2 = (NUM_CH == (1 << CH_W));

    typedef struct packed {
        logic [CH_W-1:0]   active;
        logic              valid;
        logic              ack;
        logic              err;
        logic [DATA_W-1:0] data;
        logic [TAG_W-1:0]  tag;
        logic [BL_W-1:0]   burst_left;
    } ctrl_t;

    ctrl_t      st_d, st_q;
    rd_kind_e   kind;
    logic       in_burst;
    logic       act_in_range;
    logic [CNT_W-1:0] cur_cnt;

    assign act_in_range = CH_POW2 || ({1'b0, st_q.active} < (CH_W+1)'(NUM_CH));
    assign cur_cnt      = act_in_range ? cnt_all[st_q.active] : '0;
    assign in_burst     = (st_q.burst_left != '0);

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;
        st_d.err = 1'b0;
        kind     = RD_IDLE;
        rd_pop   = 1'b0;

        if (ch_sel != st_q.active) begin
            // Switch: load the new channel, hold off reads for one cycle.
            st_d.active     = ch_sel;
            st_d.valid      = 1'b0;
            st_d.burst_left = '0;
        end else begin
            st_d.valid = 1'b1;
            if (in_burst || (st_q.valid && rd_req)) begin
                kind = (cur_cnt != '0) ? RD_DATA : RD_ERR;
            end
        end

        case (kind)
            RD_DATA: begin
                rd_pop   = 1'b1;
                st_d.ack  = 1'b1;
                st_d.data = mem_word[DATA_W-1:0];
                st_d.tag  = mem_word[DATA_W +: TAG_W];
                if (in_burst)      st_d.burst_left = st_q.burst_left - 1'b1;
                else if (rd_burst) st_d.burst_left = BL_W'(BURST_LEN - 1);
                else               st_d.burst_left = '0;
            end
            RD_ERR: begin
                st_d.err        = 1'b1;
                st_d.burst_left = '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_ch    = st_q.active;
    assign ch_valid     = st_q.valid;
    assign rd_ack       = st_q.ack;
    assign rd_err_ack   = st_q.err;
    assign rd_data      = st_q.data;
    assign rd_tag       = st_q.tag;
    assign half_empty   = (cur_cnt <= CNT_W'(DEPTH / 2));
    assign almost_empty = (cur_cnt == CNT_W'(1));

    assert_ack_err_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.ack && st_q.err));
    assert_switch_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active != $past(st_q.active)) |-> !st_q.valid);
    assert_ack_had_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ack |-> ($past(cur_cnt) != '0));
    assert_err_on_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |-> ($past(cur_cnt) == '0));
    assert_burst_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.burst_left <= BL_W'(BURST_LEN - 1));

endmodule

// File: rtl/mchan_fifo_rd.sv
`timescale 1ns/1ps
module mchan_fifo_rd #(
    parameter int NUM_CH    = 4,
    parameter int DEPTH     = 8,
    parameter int DATA_W    = 32,
    parameter int BURST_LEN = 4,
    localparam int TAG_W    = DATA_W / 8,
    localparam int CH_W     = mcf_pkg::width_for(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [CH_W-1:0]   ch_sel,
    input  logic              rd_req,
    input  logic              rd_burst,
    output logic              ch_valid,
    output logic              rd_ack,
    output logic              rd_err_ack,
    output logic [DATA_W-1:0] rd_data,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              half_empty,
    output logic              almost_empty
);
    localparam int PTR_W  = mcf_pkg::width_for(DEPTH);
    localparam int CNT_W  = PTR_W + 1;
    localparam int WORD_W = DATA_W + TAG_W;

    logic                         wr_accept;
    logic [PTR_W-1:0]             wr_ptr;
    logic [PTR_W-1:0]             rd_ptr;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_all;
    logic                         rd_pop;
    logic [CH_W-1:0]              active_ch;
    logic [WORD_W-1:0]            mem_word;

    mcf_chan_ptrs #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) ptrs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_ch     (wr_ch),
        .rd_pop    (rd_pop),
        .rd_ch     (active_ch),
        .wr_accept (wr_accept),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .cnt_all   (cnt_all)
    );

    mcf_store #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .WORD_W(WORD_W)) store_i (
        .clk   (clk),
        .we    (wr_accept),
        .wch   (wr_ch),
        .wptr  (wr_ptr),
        .wdata ({wr_tag, wr_data}),
        .rch   (active_ch),
        .rptr  (rd_ptr),
        .rdata (mem_word)
    );

    mcf_rd_ctrl #(
        .NUM_CH(NUM_CH), .DEPTH(DEPTH), .DATA_W(DATA_W), .BURST_LEN(BURST_LEN)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ch_sel       (ch_sel),
        .rd_req       (rd_req),
        .rd_burst     (rd_burst),
        .cnt_all      (cnt_all),
        .mem_word     (mem_word),
        .rd_pop       (rd_pop),
        .active_ch    (active_ch),
        .ch_valid     (ch_valid),
        .rd_ack       (rd_ack),
        .rd_err_ack   (rd_err_ack),
        .rd_data      (rd_data),
        .rd_tag       (rd_tag),
        .half_empty   (half_empty),
        .almost_empty (almost_empty)
    );

endmodule

// File: tb/mchan_fifo_rd_tb_top.sv
`timescale 1ns/1ps
module mchan_fifo_rd_tb_top;
    localparam int NCH = 4;
    localparam int DEP = 4;
    localparam int DW  = 16;
    localparam int TW  = DW / 8;
    localparam int BL  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_ch = '0;
    logic [DW-1:0] wr_data = '0;
    logic [TW-1:0] wr_tag = '0;
    logic [1:0]    ch_sel = '0;
    logic          rd_req = 1'b0;
    logic          rd_burst = 1'b0;
    logic          ch_valid, rd_ack, rd_err_ack, half_empty, almost_empty;
    logic [DW-1:0] rd_data;
    logic [TW-1:0] rd_tag;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    int seq   = 0;
    int cur   = 0;

    logic [DW+TW-1:0] mq [NCH][DEP];
    int mhead [NCH];
    int mcnt  [NCH];

    always #2.5 clk = ~clk;

    mchan_fifo_rd #(.NUM_CH(NCH), .DEPTH(DEP), .DATA_W(DW), .BURST_LEN(BL)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
        .wr_tag(wr_tag), .ch_sel(ch_sel), .rd_req(rd_req), .rd_burst(rd_burst),
        .ch_valid(ch_valid), .rd_ack(rd_ack), .rd_err_ack(rd_err_ack),
        .rd_data(rd_data), .rd_tag(rd_tag), .half_empty(half_empty),
        .almost_empty(almost_empty)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mk_data(int ch, int s);
        return DW'((ch << 12) ^ (s * 37) ^ 16'h00A5);
    endfunction

    function automatic logic [TW-1:0] mk_tag(int ch, int s);
        return TW'((s + ch) & 3);
    endfunction

    function automatic void m_push(int ch, logic [DW+TW-1:0] w);
        if (mcnt[ch] < DEP) begin
            mq[ch][(mhead[ch] + mcnt[ch]) % DEP] = w;
            mcnt[ch]++;
        end
    endfunction

    function automatic logic [DW+TW-1:0] m_pop(int ch);
        logic [DW+TW-1:0] w;
        w = mq[ch][mhead[ch]];
        mhead[ch] = (mhead[ch] + 1) % DEP;
        mcnt[ch]--;
        return w;
    endfunction

    task automatic chk_flags(string req);
        chk(half_empty == (mcnt[cur] <= DEP / 2), req, "half_empty",
            int'(half_empty), int'(mcnt[cur] <= DEP / 2));
        chk(almost_empty == (mcnt[cur] == 1), req, "almost_empty",
            int'(almost_empty), int'(mcnt[cur] == 1));
    endtask

    task automatic do_write(int ch);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = 2'(ch);
        wr_data = mk_data(ch, seq); wr_tag = mk_tag(ch, seq);
        @(posedge clk); #1;
        wr_en = 1'b0;
        m_push(ch, {mk_tag(ch, seq), mk_data(ch, seq)});
        seq++;
    endtask

    task automatic select(int ch);
        @(negedge clk);
        ch_sel = 2'(ch);
        cur = ch;
        @(negedge clk);
        chk(ch_valid == 1'b0, "R2", "ch_valid low after switch", int'(ch_valid), 0);
        @(negedge clk);
        chk(ch_valid == 1'b1, "R2", "ch_valid back high", int'(ch_valid), 1);
        chk_flags("R8");
    endtask

    // Check the response of one read beat at the current negedge.
    task automatic chk_beat(string req);
        logic [DW+TW-1:0] w;
        if (mcnt[cur] > 0) begin
            w = m_pop(cur);
            chk(rd_ack == 1'b1, req, "ack", int'(rd_ack), 1);
            chk(rd_err_ack == 1'b0, "R13", "no err with data", int'(rd_err_ack), 0);
            chk(rd_data == w[DW-1:0], req, "data", int'(rd_data), int'(w[DW-1:0]));
            chk(rd_tag == w[DW+TW-1:DW], "R5", "tag", int'(rd_tag), int'(w[DW+TW-1:DW]));
        end else begin
            chk(rd_err_ack == 1'b1, "R4", "err_ack on empty", int'(rd_err_ack), 1);
            chk(rd_ack == 1'b0, "R13", "no ack on empty", int'(rd_ack), 0);
        end
    endtask

    task automatic do_read();
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        chk_beat("R3");
        chk_flags("R7");
    endtask

    task automatic do_burst();
        bit stop;
        stop = 1'b0;
        @(negedge clk);
        rd_req = 1'b1; rd_burst = 1'b1;
        @(negedge clk);
        rd_req = 1'b0; rd_burst = 1'b0;
        for (int b = 0; b < BL && !stop; b++) begin
            if (b > 0) @(negedge clk);
            if (mcnt[cur] == 0) stop = 1'b1;
            chk_beat(stop ? "R12" : "R11");
        end
        @(negedge clk);
        chk(rd_ack == 1'b0 && rd_err_ack == 1'b0, "R12", "idle after burst",
            int'({rd_ack, rd_err_ack}), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin mhead[c] = 0; mcnt[c] = 0; end
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk(rd_ack == 1'b0 && rd_err_ack == 1'b0, "R1", "acks in reset",
            int'({rd_ack, rd_err_ack}), 0);
        chk(ch_valid == 1'b0, "R1", "ch_valid in reset", int'(ch_valid), 0);
        chk(half_empty == 1'b1 && almost_empty == 1'b0, "R1", "flags in reset",
            int'({half_empty, almost_empty}), 2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ch_valid == 1'b1, "R1", "ch_valid after reset", int'(ch_valid), 1);

        // R6 R7 R9: sweep every fill level, plus one past full, on every channel
        for (int c = 0; c < NCH; c++) begin
            if (c != cur) select(c);
            for (int k = 0; k <= DEP + 1; k++) begin
                for (int i = 0; i < k; i++) begin
                    do_write(c);
                    @(negedge clk);
                    chk_flags(mcnt[c] == 1 ? "R6" : "R7");
                end
                chk(mcnt[c] <= DEP, "R9", "model bound", mcnt[c], DEP);
                for (int i = 0; i <= ((k < DEP) ? k : DEP); i++) do_read();
            end
        end

        // R8: interleaved writes to two channels, each drained in its own order
        select(0);
        for (int i = 0; i < 3; i++) begin do_write(0); do_write(2); end
        do_write(2);
        @(negedge clk);
        chk_flags("R8");
        for (int i = 0; i < 4; i++) do_read();
        select(2);
        for (int i = 0; i < 5; i++) do_read();

        // R10: read and write on the active channel in one cycle
        do_write(2); do_write(2);
        @(negedge clk);
        rd_req = 1'b1; wr_en = 1'b1; wr_ch = 2'd2;
        wr_data = mk_data(2, seq); wr_tag = mk_tag(2, seq);
        @(negedge clk);
        rd_req = 1'b0; wr_en = 1'b0;
        chk_beat("R10");
        m_push(2, {mk_tag(2, seq), mk_data(2, seq)});
        seq++;
        chk(mcnt[2] == 2, "R10", "model count", mcnt[2], 2);
        chk_flags("R10");
        for (int i = 0; i < 3; i++) do_read();

        // R2: requests during a switch are ignored
        do_write(1);
        @(negedge clk);
        ch_sel = 2'd1; cur = 1; rd_req = 1'b1;
        @(negedge clk);
        chk(rd_ack == 1'b0 && rd_err_ack == 1'b0, "R2", "ignored at switch",
            int'({rd_ack, rd_err_ack}), 0);
        @(negedge clk);
        rd_req = 1'b0;
        chk(rd_ack == 1'b0 && rd_err_ack == 1'b0, "R2", "ignored while invalid",
            int'({rd_ack, rd_err_ack}), 0);
        chk(ch_valid == 1'b1, "R2", "ch_valid restored", int'(ch_valid), 1);
        chk_flags("R2");
        do_read();
        do_read();

        // R11: full burst; R12: burst that runs dry; burst on empty
        for (int i = 0; i < 4; i++) do_write(1);
        do_burst();
        chk(mcnt[1] == 1, "R11", "words left after burst", mcnt[1], 1);
        chk_flags("R11");
        do_write(1);
        do_burst();
        do_burst();
        chk_flags("R12");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule